// File: doc/BRIEF.md
# Subtractive GCD Processor

This block computes the greatest common divisor of two nonzero unsigned operands by repeated subtraction. It is built as a controller and a datapath. The controller is a thirteen-state machine that includes explicit wait, join and empty states. The datapath holds three registers: `x`, `y` and the result `d`. Each of `x` and `y` has a 2:1 input multiplexer. The datapath also has an equality comparator, a less-than comparator and two dedicated subtractors, one computing `x-y` and one computing `y-x`.

A user places the operands on `a_in` and `b_in` and raises `start`. The controller samples `a_in` and `b_in` in two consecutive states. While the operands differ, it subtracts the smaller from the larger. When they are equal, it copies the common value into the result register. The result register drives `gcd_out` and keeps its value until the next computation finishes. Every state lasts one clock cycle. The run time therefore follows directly from the number of subtraction steps the operands need.

Top module: `gcd_fsmd`

## Requirements
- R1: A synchronous reset puts the controller in its first state and clears `x`, `y` and the result, so `gcd_out` reads 0.
- R2: While `start` is low, the controller alternates between its wait state and the wait-join state. After `start` rises, the first edge that sees `start` high in the wait state begins the computation. If `start` was low on the wait state's last visit, that edge comes at most two edges after the rise.
- R3: `a_in` is captured only on the edge one cycle after the start edge, and `b_in` only on the edge after that. Later changes on these ports do not affect the result.
- R4: While `x` and `y` differ, each loop pass takes five cycles. The pass subtracts the smaller register from the larger. When `x` is less than `y`, `y` becomes `y-x`; otherwise `x` becomes `x-y`.
- R5: When `x` equals `y`, the result register loads `x`. Let t be the edge that sees `start` high in the wait state, and let n be the number of subtraction passes. `gcd_out` then shows the GCD after edge t+4+5n.
- R6: `gcd_out` changes only on the result-load edge. Between loads it holds its value, including while the controller waits and while it computes.
- R7: After a result load, the controller returns through a join state to the first state and then to the wait state. If `start` is high, the next start edge is the third edge after the load edge.
- R8: Each register load strobe is asserted only in its own state, and at most one load strobe is high in any cycle. The load strobes for `x`, `y` and the result are named `x_ld`, `y_ld` and `d_ld`. The controller states are binary 0 through 12 in this order: begin, wait, wait-join, load-x, load-y, compare-equal, compare-less, sub-y, sub-x, join-less, join-equal, store, join-begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a computation |
| a_in | input | W | First operand, nonzero |
| b_in | input | W | Second operand, nonzero |
| gcd_out | output | W | Result register value |

## Verification
Every result is due on a fixed edge. Let t be the edge on which `start` is sampled in the wait state. The operands are latched on edges t+1 and t+2, and the result appears after edge t+4+5n. The bench finds n by running the subtraction loop in a function. It counts edges from each known reference point and samples on the falling edge after the edge it expects. It also checks on the edge just before that `gcd_out` still shows the previous result. During idle stretches of an even number of cycles, it checks `gcd_out` every cycle. It scrambles the operand ports after they are latched and then confirms that the result is unchanged.

// File: rtl/gcd_fsmd.sv
module gcd_fsmd #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] gcd_out
);

  typedef enum logic [3:0] {
    S_BEGIN   = 4'd0,
    S_WAIT    = 4'd1,
    S_WAIT_J  = 4'd2,
    S_LD_X    = 4'd3,
    S_LD_Y    = 4'd4,
    S_CMP_EQ  = 4'd5,
    S_CMP_LT  = 4'd6,
    S_SUB_Y   = 4'd7,
    S_SUB_X   = 4'd8,
    S_LT_J    = 4'd9,
    S_EQ_J    = 4'd10,
    S_STORE   = 4'd11,
    S_BEGIN_J = 4'd12
  } state_t;

  state_t state, state_n;

  logic [W-1:0] x, y, d;
  logic         x_sel, y_sel, x_ld, y_ld, d_ld;
  logic         x_neq_y, x_lt_y;
  logic [W-1:0] x_minus_y, y_minus_x;

  // datapath
  assign x_neq_y   = (x != y);
  assign x_lt_y    = (x < y);
  assign x_minus_y = x - y;
  assign y_minus_x = y - x;
  assign gcd_out   = d;

  always_ff @(posedge clk) begin
    if (rst) begin
      x <= '0;
      y <= '0;
      d <= '0;
    end else begin
      if (x_ld) x <= x_sel ? x_minus_y : a_in;
      if (y_ld) y <= y_sel ? y_minus_x : b_in;
      if (d_ld) d <= x;
    end
  end

  // controller: control outputs default to 0
  always_comb begin
    x_sel = 1'b0;
    y_sel = 1'b0;
    x_ld  = 1'b0;
    y_ld  = 1'b0;
    d_ld  = 1'b0;
    unique case (state)
      S_LD_X:  x_ld = 1'b1;
      S_LD_Y:  y_ld = 1'b1;
      S_SUB_Y: begin y_sel = 1'b1; y_ld = 1'b1; end
      S_SUB_X: begin x_sel = 1'b1; x_ld = 1'b1; end
      S_STORE: d_ld = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_n = state;
    unique case (state)
      S_BEGIN:   state_n = S_WAIT;
      S_WAIT:    state_n = start ? S_LD_X : S_WAIT_J;
      S_WAIT_J:  state_n = S_WAIT;
      S_LD_X:    state_n = S_LD_Y;
      S_LD_Y:    state_n = S_CMP_EQ;
      S_CMP_EQ:  state_n = x_neq_y ? S_CMP_LT : S_STORE;
      S_CMP_LT:  state_n = x_lt_y ? S_SUB_Y : S_SUB_X;
      S_SUB_Y:   state_n = S_LT_J;
      S_SUB_X:   state_n = S_LT_J;
      S_LT_J:    state_n = S_EQ_J;
      S_EQ_J:    state_n = S_CMP_EQ;
      S_STORE:   state_n = S_BEGIN_J;
      S_BEGIN_J: state_n = S_BEGIN;
      default:   state_n = S_BEGIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_BEGIN;
    else     state <= state_n;
  end

endmodule

// File: rtl/gcd_fsmd_chk.sv
module gcd_fsmd_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [3:0]   state,
  input logic [W-1:0] x,
  input logic [W-1:0] y,
  input logic [W-1:0] gcd_out,
  input logic         x_ld,
  input logic         y_ld,
  input logic         d_ld,
  input logic         x_lt_y
);

  localparam logic [3:0] C_BEGIN = 4'd0, C_WAIT = 4'd1, C_WAIT_J = 4'd2,
                         C_LD_X = 4'd3, C_CMP_LT = 4'd6, C_SUB_Y = 4'd7,
                         C_SUB_X = 4'd8, C_STORE = 4'd11;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (state == C_BEGIN && gcd_out == '0)); // R1
  AST_WAIT_IDLE:   assert property (@(posedge clk) disable iff (rst) (state == C_WAIT && !start) |=> state == C_WAIT_J); // R2
  AST_WAIT_GO:     assert property (@(posedge clk) disable iff (rst) (state == C_WAIT && start) |=> state == C_LD_X); // R2
  AST_LT_BRANCH:   assert property (@(posedge clk) disable iff (rst) (state == C_CMP_LT && x_lt_y) |=> state == C_SUB_Y); // R4
  AST_SUB_Y_VAL:   assert property (@(posedge clk) disable iff (rst) state == C_SUB_Y |=> y == $past(y) - $past(x)); // R4
  AST_SUB_X_VAL:   assert property (@(posedge clk) disable iff (rst) state == C_SUB_X |=> x == $past(x) - $past(y)); // R4
  AST_STORE_VAL:   assert property (@(posedge clk) disable iff (rst) state == C_STORE |=> gcd_out == $past(x)); // R5
  AST_OUT_HOLD:    assert property (@(posedge clk) disable iff (rst) !d_ld |=> $stable(gcd_out)); // R6
  AST_BEGIN_STEP:  assert property (@(posedge clk) disable iff (rst) state == C_BEGIN |=> state == C_WAIT); // R7
  AST_LOAD_EXCL:   assert property (@(posedge clk) disable iff (rst) $onehot0({x_ld, y_ld, d_ld})); // R8
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst) state <= 4'd12); // R8
  AST_WAITJ_BACK:  assert property (@(posedge clk) disable iff (rst) state == C_WAIT_J |=> state == C_WAIT); // R2

endmodule

bind gcd_fsmd gcd_fsmd_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .state(state), .x(x), .y(y),
  .gcd_out(gcd_out), .x_ld(x_ld), .y_ld(y_ld), .d_ld(d_ld), .x_lt_y(x_lt_y)
);

// File: tb/sim_gcd_fsmd.sv
module sim_gcd_fsmd;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] gcd_out;

  int total = 0;
  int bad = 0;
  logic [W-1:0] prev = '0;

  gcd_fsmd #(.W(W)) u0 (.clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in), .gcd_out(gcd_out));

  always #5 clk = ~clk;

  function automatic int passes(input logic [W-1:0] a, input logic [W-1:0] b);
    int n = 0;
    while (a != b) begin
      if (a < b) b = b - a; else a = a - b;
      n++;
    end
    return n;
  endfunction

  function automatic logic [W-1:0] gcd_ref(input logic [W-1:0] a, input logic [W-1:0] b);
    while (b != 0) begin
      logic [W-1:0] t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // entry: just after an edge that leaves the controller in its first state
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input int idle_pairs);
    int n = passes(a, b);
    logic [W-1:0] g = gcd_ref(a, b);
    a_in = a;
    b_in = b;
    start = (idle_pairs == 0);
    for (int i = 0; i < 2 * idle_pairs; i++) begin
      step();
      check("R2 R6 idle hold", gcd_out, prev);
    end
    start = 1'b1;
    repeat (4) step();
    a_in = W'($urandom);
    b_in = W'($urandom);
    repeat (5 * n + 1) step();
    check("R6 hold before load", gcd_out, prev);
    step();
    check(idle_pairs == 0 ? "R3 R4 R5 R7 result back-to-back" : "R3 R4 R5 R8 result", gcd_out, g);
    prev = g;
    step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    check("R1 reset output", gcd_out, '0);
    rst = 1'b0;
    run(8'd12, 8'd18, 1);
    run(8'd5, 8'd5, 0);
    run(8'd1, 8'd255, 2);
    run(8'd255, 8'd1, 0);
    run(8'd128, 8'd64, 3);
    run(8'd255, 8'd255, 0);
    run(8'd17, 8'd13, 1);
    for (int k = 0; k < 30; k++) begin
      logic [W-1:0] a = W'($urandom_range(1, (1 << W) - 1));
      logic [W-1:0] b = W'($urandom_range(1, (1 << W) - 1));
      run(a, b, int'($urandom_range(0, 3)));
    end
    rst = 1'b1;
    step();
    check("R1 reset clears result", gcd_out, '0);
    prev = '0;
    rst = 1'b0;
    run(8'd36, 8'd24, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule